// File: doc/BRIEF.md
# Status-Modified Interrupt Vector Former

This block builds the 8-bit interrupt vector that a dual-channel serial controller hands out when an interrupt is acknowledged or when software reads the vector register. It starts from a programmed base vector. When the status-modifies-vector option is on, it folds in a short code for the channel and the event type of the winning interrupt source. The bit positions of that code depend on which register layout is selected, native or alternate. In the alternate layout they also depend on a two-bit bus mode field.

The result is kept in a vector register. The register loads when a new interrupt is raised (`raise_i`) and when channel B reads the vector. It holds its value at every other time. A read from channel A always returns zero and leaves the register alone. A channel-B read with no source pending loads a fixed idle pattern. In the alternate layout, that idle read also sends a one-cycle request to clear the controller's global interrupt-pending flag. The arbitration that picks the winning source sits outside this block, which only receives its result.

Top module: `irq_vector_former`

## Requirements
- R1: With `sav_en_i` = 0, a raise (`raise_i` = 1 with no channel-B read in the same cycle) loads `base_i` into `vec_q_o` unchanged, one clock later. This holds in both layouts.
- R2: Source encodings used throughout: `src_chan_i` 0 = channel A, 1 = channel B; `src_kind_i` 0 = transmit, 1 = external/status, 2 = receive, 3 = special receive. In the native layout (`alt_sel_i` = 0) with `sav_en_i` = 1, a raise loads `(base & 0xF1) | (~chan << 3) | (kind << 1)`.
- R3: In the alternate layout (`alt_sel_i` = 1) with `sav_en_i` = 1, the source code is the 3-bit value `{~chan, kind}`. When `bus_mode_i` equals `DIRECT_MODE` (default 2'b00), a raise loads `(base & 0xF8) | code`.
- R4: In the alternate layout with `sav_en_i` = 1 and any other `bus_mode_i`, a raise loads `(base & 0xE3) | (code << 2)`.
- R5: In the alternate layout, a channel-B read (`rd_i` = 1, `rd_chan_i` = 1) while `src_valid_i` = 0 loads `base | 0x1F`. `clr_pend_o` is then high for exactly the following cycle.
- R6: In the native layout, a channel-B read while `src_valid_i` = 0 loads `(base & 0xF1) | 0x06` (V3 = 0, V2 = 1, V1 = 1) when `sav_en_i` = 1, and `base` when `sav_en_i` = 0. `clr_pend_o` stays low.
- R7: A read with `rd_chan_i` = 0 (channel A) returns `rd_data_o` = 0 one clock later and leaves `vec_q_o` unchanged.
- R8: With neither a raise nor a channel-B read, `vec_q_o` holds its value. When a raise and a channel-B read fall in the same cycle, the read's result is loaded.
- R9: A channel-B read with `src_valid_i` = 1 loads the vector that R1 to R4 give for the presented source. One clock after the read, `rd_data_o` equals the new `vec_q_o`.
- R10: After reset, `vec_q_o`, `rd_data_o` and `clr_pend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | 8 | Programmed base vector |
| sav_en_i | input | 1 | Status modifies vector enable |
| alt_sel_i | input | 1 | 0 native layout, 1 alternate layout |
| bus_mode_i | input | 2 | Bus mode field used by the alternate layout |
| src_valid_i | input | 1 | A source is pending |
| src_chan_i | input | 1 | Channel of the winning source (0 A, 1 B) |
| src_kind_i | input | 2 | Event type of the winning source |
| raise_i | input | 1 | A new interrupt is raised this cycle |
| rd_i | input | 1 | Vector register read strobe |
| rd_chan_i | input | 1 | Channel the read targets (0 A, 1 B) |
| vec_q_o | output | 8 | Vector register, also the acknowledge vector |
| rd_data_o | output | 8 | Read data, one cycle after the strobe |
| clr_pend_o | output | 1 | One-cycle request to clear global pending |

## Verification
Random base vectors are combined with every layout, bus mode, channel and type. This tells apart the three merge placements, and it also checks that base bits outside each mask survive, which a stuck or misplaced mask would break. Directed reads with no pending source use all-zero and all-ones bases. These separate the native idle code from the alternate all-ones fill and show whether the clear-pending pulse appears. Channel-A reads, idle cycles and raises that coincide with a read check that the register holds and that the read takes priority.

// File: rtl/ivec_pkg.sv
package ivec_pkg;

   // Event type carried by an interrupt source.
   typedef enum logic [1:0] {
      KIND_TX  = 2'd0,
      KIND_EXT = 2'd1,
      KIND_RX  = 2'd2,
      KIND_SPC = 2'd3
   } src_kind_e;

   // Channel selector value for the channel allowed to read the vector.
   localparam logic CHAN_A = 1'b0;
   localparam logic CHAN_B = 1'b1;

   // Load source chosen for the vector register.
   typedef enum logic [1:0] {
      LD_NONE   = 2'd0,
      LD_SOURCE = 2'd1,
      LD_IDLE   = 2'd2
   } load_sel_e;

endpackage

// File: rtl/ivec_merge.sv
module ivec_merge
   import ivec_pkg::*;
#(
   parameter int         VW          = 8,
   parameter bit         HAS_ALT     = 1'b1,
   parameter logic [1:0] DIRECT_MODE = 2'b00
) (
   input  logic [VW-1:0] base_i,
   input  logic          sav_en_i,
   input  logic          alt_sel_i,
   input  logic [1:0]    bus_mode_i,
   input  logic          chan_i,
   input  logic [1:0]    kind_i,
   output logic [VW-1:0] vec_o
);

   localparam int            CODE_W   = 3;
   localparam logic [VW-1:0] NAT_KEEP = VW'(8'hF1);
   localparam logic [VW-1:0] DIR_KEEP = VW'(8'hF8);
   localparam logic [VW-1:0] SHF_KEEP = VW'(8'hE3);

   if (VW != 8) begin : g_width_check
      $error("ivec_merge: VW must be 8");
   end

   logic [CODE_W-1:0] code;
   logic [VW-1:0]     nat_vec;
   logic [VW-1:0]     alt_vec;

   assign code    = {~chan_i, kind_i};
   assign nat_vec = (base_i & NAT_KEEP) | VW'({code, 1'b0});

   if (HAS_ALT) begin : g_alt
      logic [VW-1:0] dir_vec;
      logic [VW-1:0] shf_vec;
      assign dir_vec = (base_i & DIR_KEEP) | VW'(code);
      assign shf_vec = (base_i & SHF_KEEP) | VW'({code, 2'b00});
      always_comb begin
         if (!sav_en_i)                      vec_o = base_i;
         else if (!alt_sel_i)                vec_o = nat_vec;
         else if (bus_mode_i == DIRECT_MODE) vec_o = dir_vec;
         else                                vec_o = shf_vec;
      end
   end else begin : g_native_only
      logic unused_alt;
      assign unused_alt = alt_sel_i ^ (^bus_mode_i);
      assign vec_o = sav_en_i ? nat_vec : base_i;
   end

endmodule

// File: rtl/ivec_idle.sv
module ivec_idle
   import ivec_pkg::*;
#(
   parameter int VW      = 8,
   parameter bit HAS_ALT = 1'b1
) (
   input  logic [VW-1:0] base_i,
   input  logic          sav_en_i,
   input  logic          alt_sel_i,
   output logic [VW-1:0] idle_o,
   output logic          clr_req_o
);

   localparam logic [VW-1:0] NAT_KEEP  = VW'(8'hF1);
   localparam logic [VW-1:0] NAT_IDLE  = VW'(8'h06);
   localparam logic [VW-1:0] ALT_FILL  = VW'(8'h1F);

   logic [VW-1:0] nat_idle;
   assign nat_idle = sav_en_i ? ((base_i & NAT_KEEP) | NAT_IDLE) : base_i;

   if (HAS_ALT) begin : g_alt
      assign idle_o    = alt_sel_i ? (base_i | ALT_FILL) : nat_idle;
      assign clr_req_o = alt_sel_i;
   end else begin : g_native_only
      logic unused_sel;
      assign unused_sel = alt_sel_i;
      assign idle_o     = nat_idle;
      assign clr_req_o  = 1'b0;
   end

endmodule

// File: rtl/ivec_hold.sv
module ivec_hold
   import ivec_pkg::*;
#(
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  load_sel_e     sel_i,
   input  logic [VW-1:0] src_vec_i,
   input  logic [VW-1:0] idle_vec_i,
   input  logic          rd_a_i,
   input  logic          rd_b_i,
   input  logic          clr_req_i,
   output logic [VW-1:0] vec_q_o,
   output logic [VW-1:0] rd_data_o,
   output logic          clr_pend_o
);

   logic [VW-1:0] vec_d;

   always_comb begin
      unique case (sel_i)
         LD_SOURCE: vec_d = src_vec_i;
         LD_IDLE:   vec_d = idle_vec_i;
         default:   vec_d = vec_q_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q_o    <= '0;
         rd_data_o  <= '0;
         clr_pend_o <= 1'b0;
      end else begin
         vec_q_o    <= vec_d;
         clr_pend_o <= (sel_i == LD_IDLE) && clr_req_i;
         if (rd_b_i)      rd_data_o <= vec_d;
         else if (rd_a_i) rd_data_o <= '0;
      end
   end

endmodule

// File: rtl/irq_vector_former.sv
module irq_vector_former
   import ivec_pkg::*;
#(
   parameter int         VW          = 8,
   parameter bit         HAS_ALT     = 1'b1,
   parameter logic [1:0] DIRECT_MODE = 2'b00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] base_i,
   input  logic          sav_en_i,
   input  logic          alt_sel_i,
   input  logic [1:0]    bus_mode_i,
   input  logic          src_valid_i,
   input  logic          src_chan_i,
   input  logic [1:0]    src_kind_i,
   input  logic          raise_i,
   input  logic          rd_i,
   input  logic          rd_chan_i,
   output logic [VW-1:0] vec_q_o,
   output logic [VW-1:0] rd_data_o,
   output logic          clr_pend_o
);

   logic [VW-1:0] src_vec;
   logic [VW-1:0] idle_vec;
   logic          clr_req;
   logic          rd_b;
   logic          rd_a;
   load_sel_e     sel;

   assign rd_b = rd_i && (rd_chan_i == CHAN_B);
   assign rd_a = rd_i && (rd_chan_i == CHAN_A);

   always_comb begin
      if (rd_b)         sel = src_valid_i ? LD_SOURCE : LD_IDLE;
      else if (raise_i) sel = LD_SOURCE;
      else              sel = LD_NONE;
   end

   ivec_merge #(.VW(VW), .HAS_ALT(HAS_ALT), .DIRECT_MODE(DIRECT_MODE)) u_merge (
      .base_i     (base_i),
      .sav_en_i   (sav_en_i),
      .alt_sel_i  (alt_sel_i),
      .bus_mode_i (bus_mode_i),
      .chan_i     (src_chan_i),
      .kind_i     (src_kind_i),
      .vec_o      (src_vec)
   );

   ivec_idle #(.VW(VW), .HAS_ALT(HAS_ALT)) u_idle (
      .base_i    (base_i),
      .sav_en_i  (sav_en_i),
      .alt_sel_i (alt_sel_i),
      .idle_o    (idle_vec),
      .clr_req_o (clr_req)
   );

   ivec_hold #(.VW(VW)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel),
      .src_vec_i  (src_vec),
      .idle_vec_i (idle_vec),
      .rd_a_i     (rd_a),
      .rd_b_i     (rd_b),
      .clr_req_i  (clr_req),
      .vec_q_o    (vec_q_o),
      .rd_data_o  (rd_data_o),
      .clr_pend_o (clr_pend_o)
   );

   // R7: channel A read returns zero and leaves the register alone
   p_chan_a_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !rd_chan_i && !raise_i) |=> (rd_data_o == '0) && $stable(vec_q_o));

   // R8: no load request keeps the register
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!raise_i && !(rd_i && rd_chan_i)) |=> $stable(vec_q_o));

   // R1: bypass when status does not modify the vector
   p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_i && !rd_i && !sav_en_i) |=> (vec_q_o == $past(base_i)));

   // R5: alternate idle read fills low bits and requests a pending clear
   p_alt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_ALT && alt_sel_i && rd_i && rd_chan_i && !src_valid_i)
      |=> clr_pend_o && (vec_q_o[4:0] == 5'h1F));

   // R6: native reads never request a pending clear
   p_nat_no_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!alt_sel_i) |=> !clr_pend_o);

   // R9: channel B read data matches the register
   p_rd_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && rd_chan_i) |=> (rd_data_o == vec_q_o));

endmodule

// File: tb/irq_vector_former_test.sv
module irq_vector_former_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] base;
   logic       sav, alt, sv, sc, raise, rd, rdc;
   logic [1:0] mode, sk;
   logic [7:0] vec_q, rd_data;
   logic       clr_pend;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] mdl_vec;
   logic [7:0] mdl_rd;

   always #4 clk = ~clk;

   irq_vector_former uut (
      .clk(clk), .rst_n(rst_n), .base_i(base), .sav_en_i(sav), .alt_sel_i(alt),
      .bus_mode_i(mode), .src_valid_i(sv), .src_chan_i(sc), .src_kind_i(sk),
      .raise_i(raise), .rd_i(rd), .rd_chan_i(rdc),
      .vec_q_o(vec_q), .rd_data_o(rd_data), .clr_pend_o(clr_pend)
   );

   function automatic logic [7:0] f_merge(logic [7:0] b, logic s, logic a,
                                          logic [1:0] m, logic c, logic [1:0] k);
      logic [2:0] code;
      code = {~c, k};
      if (!s) return b;
      if (!a) return (b & 8'hF1) | {4'b0, code, 1'b0};
      if (m == 2'b00) return (b & 8'hF8) | {5'b0, code};
      return (b & 8'hE3) | {3'b0, code, 2'b00};
   endfunction

   function automatic logic [7:0] f_idle(logic [7:0] b, logic s, logic a);
      if (a) return b | 8'h1F;
      if (s) return (b & 8'hF1) | 8'h06;
      return b;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Applies one cycle of stimulus and checks the outputs afterwards.
   task automatic step(logic [7:0] b, logic s, logic a, logic [1:0] m, logic v,
                       logic c, logic [1:0] k, logic r, logic rr, logic rc, string req);
      logic exp_clr;
      base = b; sav = s; alt = a; mode = m; sv = v; sc = c; sk = k;
      raise = r; rd = rr; rdc = rc;
      exp_clr = 1'b0;
      if (rr && rc) begin
         mdl_vec = v ? f_merge(b, s, a, m, c, k) : f_idle(b, s, a);
         exp_clr = a && !v;
         mdl_rd  = mdl_vec;
      end else begin
         if (r) mdl_vec = f_merge(b, s, a, m, c, k);
         if (rr) mdl_rd = 8'h00;
      end
      @(negedge clk);
      check(req, vec_q, mdl_vec);
      if (rr) check(req, rd_data, mdl_rd);
      check(req, {7'b0, clr_pend}, {7'b0, exp_clr});
      raise = 1'b0; rd = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      rst_n = 1'b0; base = 8'h00; sav = 0; alt = 0; mode = 0; sv = 0; sc = 0;
      sk = 0; raise = 0; rd = 0; rdc = 0;
      mdl_vec = 8'h00; mdl_rd = 8'h00;
      repeat (3) @(negedge clk);
      check("R10", vec_q, 8'h00);
      check("R10", rd_data, 8'h00);
      check("R10", {7'b0, clr_pend}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      step(8'hA5, 0, 0, 2'd0, 1, 0, 2'd3, 1, 0, 0, "R1");
      step(8'h3C, 0, 1, 2'd2, 1, 1, 2'd1, 1, 0, 0, "R1");
      step(8'h00, 1, 0, 2'd0, 1, 0, 2'd3, 1, 0, 0, "R2");
      check("R2", vec_q, 8'h0E);
      step(8'hFF, 1, 0, 2'd1, 1, 1, 2'd0, 1, 0, 0, "R2");
      check("R2", vec_q, 8'hF1);
      step(8'hFF, 1, 1, 2'd0, 1, 1, 2'd2, 1, 0, 0, "R3");
      check("R3", vec_q, 8'hFA);
      step(8'h00, 1, 1, 2'd3, 1, 0, 2'd1, 1, 0, 0, "R4");
      check("R4", vec_q, 8'h14);
      step(8'h00, 1, 1, 2'd1, 0, 0, 2'd0, 0, 1, 1, "R5");
      check("R5", vec_q, 8'h1F);
      step(8'h40, 1, 1, 2'd1, 0, 0, 2'd0, 0, 0, 0, "R5");
      step(8'hFF, 1, 0, 2'd0, 0, 0, 2'd0, 0, 1, 1, "R6");
      check("R6", vec_q, 8'hF7);
      step(8'h00, 1, 0, 2'd0, 0, 0, 2'd0, 0, 1, 1, "R6");
      check("R6", vec_q, 8'h06);
      step(8'h81, 0, 0, 2'd0, 0, 0, 2'd0, 0, 1, 1, "R6");
      step(8'h55, 1, 1, 2'd0, 1, 1, 2'd3, 0, 1, 0, "R7");
      step(8'h12, 1, 0, 2'd0, 1, 0, 2'd2, 0, 0, 0, "R8");
      step(8'h77, 1, 0, 2'd0, 1, 0, 2'd1, 1, 1, 1, "R9");
      step(8'h77, 1, 1, 2'd0, 0, 0, 2'd1, 1, 1, 1, "R8");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         logic r, rr, rc;
         op = $urandom_range(0, 5);
         r  = (op == 0) || (op == 4);
         rr = (op == 1) || (op == 2) || (op == 4);
         rc = (op != 2);
         step(8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
              1'($urandom_range(0, 3) != 0), 1'($urandom), 2'($urandom),
              r, rr, rc,
              (op == 2) ? "R7" : (op == 3 || op == 5) ? "R8" : rr ? "R9" : "R2");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule